// File: doc/BRIEF.md
# Palette Mask-Port Hidden Control Unlock

This block guards an extra 8-bit control register that sits behind the palette pixel-mask port. It sees every bus access to the four palette ports: mask, read index, write index and data. Software reaches the hidden register by reading the mask port a fixed number of times in a row, four by default. The access to the mask port that follows then goes to the hidden register and not to the normal mask. Any access to another palette port cancels a partly built or completed sequence. So does a mask access that has already reached the hidden register.

The block also works out the effective pixel depth. It combines a sequencer extension register, supplied as an input, with bit 0 of the hidden control value. The palette RAM, the normal mask register and any timing work are outside the block. A surrounding decoder uses `hidden_hit` to route the current mask access away from the normal mask.

Top module: `pal_hidden_ctl`

## Requirements
- R1: After reset the unlock count is 0, `hidden_armed` is 0, `hidden_ctl` is 0x00 and `pixel_bpp` is 8 (extension input 0).
- R2: Each read of the mask port (`acc_port` = 2'b00, `acc_write` = 0) made while not armed adds one to the count. After ARM_READS such reads back to back, `hidden_armed` is 1 from the next cycle. The count never exceeds ARM_READS.
- R3: A mask-port read while armed raises `hidden_hit` in the same cycle and drives `hidden_rdata` with `hidden_ctl`. From the next cycle the block is disarmed and the count is 0. `hidden_rdata` is 0x00 whenever `hidden_hit` is 0.
- R4: A mask-port write while armed raises `hidden_hit`, loads `acc_wdata` into `hidden_ctl` from the next cycle, and clears the count.
- R5: A mask-port write while not armed leaves `hidden_ctl` unchanged, keeps `hidden_hit` at 0 and clears the count.
- R6: A read or write of the read-index (2'b01), write-index (2'b10) or data (2'b11) port clears the count and disarms the block. It never raises `hidden_hit`.
- R7: Cycles with `acc_valid` = 0 change neither the count nor `hidden_ctl`.
- R8: When bit 0 of `ext_mode` is 0, `pixel_bpp` is 8 whatever the other bits are.
- R9: When bit 0 of `ext_mode` is 1, field `ext_mode[3:1]` sets the depth: 0 gives 8, 2 gives 24, 4 gives 32, 1 and 3 give the 16-bit class, and 5 to 7 give 8.
- R10: In the 16-bit class, `pixel_bpp` is 16 when `hidden_ctl[0]` is 1 and 15 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A palette port access happens this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_port | input | 2 | 00 mask, 01 read index, 10 write index, 11 data |
| acc_wdata | input | 8 | Write data |
| ext_mode | input | 8 | Sequencer extension register value |
| hidden_hit | output | 1 | The current mask access goes to the hidden register |
| hidden_rdata | output | 8 | Hidden value for a hidden read, else 0x00 |
| hidden_armed | output | 1 | The next mask access goes to the hidden register |
| hidden_ctl | output | 8 | Hidden control register value |
| pixel_bpp | output | 6 | Effective bits per pixel (8, 15, 16, 24 or 32) |

## Verification
The bench builds the block with its default of four arming reads and an 8-bit data path. This makes a full unlock short enough to run many times. It sweeps all 256 extension values against both states of the hidden bit 0. A long pseudo-random walk over the four ports, mixing reads, writes and idle cycles, is checked against a counter model kept in the bench. This covers interrupted sequences, writes arriving before the block is armed, and repeated unlocks.

// File: rtl/pal_hidden_ctl.sv
module pal_hidden_ctl #(
  parameter int ARM_READS = 4,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_port,
  input  logic [DW-1:0] acc_wdata,
  input  logic [7:0]    ext_mode,
  output logic          hidden_hit,
  output logic [DW-1:0] hidden_rdata,
  output logic          hidden_armed,
  output logic [DW-1:0] hidden_ctl,
  output logic [5:0]    pixel_bpp
);
  localparam int CW = $clog2(ARM_READS + 1);
  localparam logic [CW-1:0] ARM_CNT = CW'(ARM_READS);
  localparam logic [1:0] PORT_MASK = 2'b00;

  logic [CW-1:0] cnt;
  logic          mask_acc;

  assign mask_acc     = acc_valid && (acc_port == PORT_MASK);
  assign hidden_armed = (cnt == ARM_CNT);
  assign hidden_hit   = mask_acc && hidden_armed;
  assign hidden_rdata = (hidden_hit && !acc_write) ? hidden_ctl : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      hidden_ctl <= '0;
    end else if (acc_valid) begin
      if (mask_acc && !acc_write && !hidden_armed)
        cnt <= cnt + 1'b1;
      else
        cnt <= '0;
      if (hidden_hit && acc_write)
        hidden_ctl <= acc_wdata;
    end
  end

  always_comb begin
    pixel_bpp = 6'd8;
    if (ext_mode[0]) begin
      case (ext_mode[3:1])
        3'd1, 3'd3: pixel_bpp = hidden_ctl[0] ? 6'd16 : 6'd15;
        3'd2:       pixel_bpp = 6'd24;
        3'd4:       pixel_bpp = 6'd32;
        default:    pixel_bpp = 6'd8;
      endcase
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ARM_CNT);
  p_arm_after_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_acc && !acc_write && cnt == ARM_CNT - 1'b1) |=> hidden_armed);
  p_hidden_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hidden_hit && !acc_write) |=> (!hidden_armed && $stable(hidden_ctl)));
  p_hidden_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hidden_hit && acc_write) |=> (hidden_ctl == $past(acc_wdata) && cnt == '0));
  p_plain_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_acc && acc_write && !hidden_armed) |=> ($stable(hidden_ctl) && cnt == '0));
  p_other_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_port != PORT_MASK) |=> (cnt == '0 && $stable(hidden_ctl)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(cnt) && $stable(hidden_ctl)));
  p_ext_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode[0] |-> pixel_bpp == 6'd8);
  p_class16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode[0] && ext_mode[1] && !ext_mode[2] && !ext_mode[3]) |-> (pixel_bpp[5:1] == 5'd8 || pixel_bpp[5:1] == 5'd7));
endmodule

// File: tb/pal_hidden_ctl_bench.sv
module pal_hidden_ctl_bench;
  localparam int PERIOD = 10;
  localparam int ARM = 4;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [1:0] acc_port = 0;
  logic [7:0] acc_wdata = 0, ext_mode = 0;
  logic hidden_hit, hidden_armed;
  logic [7:0] hidden_rdata, hidden_ctl;
  logic [5:0] pixel_bpp;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_cnt = 0;
  logic [7:0] m_ctl = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  pal_hidden_ctl #(.ARM_READS(ARM), .DW(8)) u_pal_hidden_ctl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .ext_mode(ext_mode),
    .hidden_hit(hidden_hit), .hidden_rdata(hidden_rdata), .hidden_armed(hidden_armed),
    .hidden_ctl(hidden_ctl), .pixel_bpp(pixel_bpp));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bpp(input logic [7:0] e, input logic c0);
    if (!e[0]) return 8;
    case (e[3:1])
      3'd1, 3'd3: return c0 ? 16 : 15;
      3'd2: return 24;
      3'd4: return 32;
      default: return 8;
    endcase
  endfunction

  task automatic access(input logic [1:0] p, input logic w, input logic [7:0] d, input bit valid);
    bit mhit;
    string tag;
    @(negedge clk);
    acc_valid = valid; acc_port = p; acc_write = w; acc_wdata = d;
    #1;
    mhit = valid && p == 2'b00 && m_cnt == ARM;
    tag = (p != 2'b00) ? "R6" : (w ? (mhit ? "R4" : "R5") : (mhit ? "R3" : "R2"));
    if (!valid) tag = "R7";
    chk({tag, " hit"}, hidden_hit, mhit);
    chk("R3 rdata", hidden_rdata, (mhit && !w) ? m_ctl : 0);
    if (valid) begin
      if (p == 2'b00 && !w && m_cnt != ARM) m_cnt++;
      else m_cnt = 0;
      if (mhit && w) m_ctl = d;
    end
    @(posedge clk); #1;
    acc_valid = 0;
    chk({tag, " armed"}, hidden_armed, m_cnt == ARM);
    chk({tag, " ctl"}, hidden_ctl, m_ctl);
  endtask

  task automatic load_ctl(input logic [7:0] v);
    for (int i = 0; i < ARM; i++) access(2'b00, 0, 8'h00, 1);
    access(2'b00, 1, v, 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 armed", hidden_armed, 0);
    chk("R1 ctl", hidden_ctl, 0);
    chk("R1 bpp", pixel_bpp, 8);
    @(negedge clk); rst_n = 1;

    // R2/R3: unlock then hidden read
    load_ctl(8'h5A);
    for (int i = 0; i < ARM; i++) access(2'b00, 0, 0, 1);
    access(2'b00, 0, 0, 1);
    // R5: write before armed
    access(2'b00, 0, 0, 1);
    access(2'b00, 1, 8'hFF, 1);
    // R6: interruption by each other port
    for (int p = 1; p < 4; p++) begin
      for (int i = 0; i < ARM - 1; i++) access(2'b00, 0, 0, 1);
      access(2'(p), p[0], 8'h33, 1);
      access(2'b00, 1, 8'hEE, 1);
    end
    // R7: idle cycles in middle of sequence
    access(2'b00, 0, 0, 1);
    access(2'b00, 0, 0, 0);
    access(2'b01, 1, 0, 0);
    for (int i = 0; i < ARM - 1; i++) access(2'b00, 0, 0, 1);
    access(2'b00, 1, 8'hC3, 1);

    // R8/R9/R10 sweep
    for (int c = 0; c < 2; c++) begin
      load_ctl(8'(c) | 8'h40);
      for (int e = 0; e < 256; e++) begin
        @(negedge clk); ext_mode = 8'(e); #1;
        chk(e[0] ? ((e[3:1] == 1 || e[3:1] == 3) ? "R10 bpp" : "R9 bpp") : "R8 bpp",
            pixel_bpp, exp_bpp(8'(e), 1'(c)));
      end
    end
    ext_mode = 0;

    // random walk
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access((lfsr[3:2] == 2'b11 && lfsr[4]) ? lfsr[1:0] : 2'b00,
             lfsr[5] & lfsr[6], lfsr[15:8], lfsr[7] | lfsr[9]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule